// File: doc/BRIEF.md
# Multi-Channel Message Mailbox

This block is the handshake keeper for message passing between a host and a coprocessor over a small window of shared RAM. The window holds two regions. In the outbound region the host sends and the coprocessor answers. In the inbound region the roles swap. Each region has up to seven channels. Each channel owns a two-bit state byte and a 32-byte message slot. Either side reaches the window through one byte-wide access port and marks itself with a side bit on every access.

On every write the block checks the state byte and slot writes against a four-step ownership cycle. The sequence runs idle, new, picked up, complete, and back to idle. A write that breaks the cycle is refused and marks an error flag for that channel. A level interrupt goes to each side while it has work waiting: a fresh message to pick up, or a finished reply to collect. The block never looks at what the messages mean.

Top module: `msg_mailbox`

## Requirements
- R1: After reset, every channel state is idle (0), every slot byte reads 0, both channel-count bytes read 7, both interrupts are low and all error flags are 0.
- R2: The outbound region occupies 0x0200..0x02FF and the inbound region occupies 0x0300..0x03FF. Within a region, the state of channel n is at offset 0x01+n and reads as {6'b0, state}. Byte k of channel n's slot is at offset 0x20+32n+k. Read data appears on rdata_o in the cycle after the request. Addresses outside both regions read 0 and ignore writes.
- R3: side_i=0 is the host and side_i=1 is the coprocessor. The host is the sender in the outbound region and the coprocessor is the sender in the inbound region. The other side is the receiver.
- R4: A state write is accepted only for these four steps: sender writes 0x01 while idle (0), receiver writes 0x02 while new (1), receiver writes 0x03 while received (2), sender writes 0x00 while complete (3). Any other state write leaves the state unchanged.
- R5: A slot write is accepted only from the sender while the channel is idle, or from the receiver while the channel is received (2). A refused slot write leaves the slot unchanged.
- R6: err_o bit d*7+n (d=0 outbound, d=1 inbound) goes to 1 on any refused state or slot write to that channel. It holds until the next accepted state write on that channel clears it.
- R7: Offset 0x00 of each region is a read/write channel-count byte, reset to 7. A state or slot write to a channel n with n not below that count is refused (and flagged per R6).
- R8: cop_irq_o is high while any outbound channel is new or any inbound channel is complete. host_irq_o is high while any inbound channel is new or any outbound channel is complete.
- R9: Offset 0x1F of each region is a plain read/write byte for either side. Offsets 0x08..0x1E read 0 and ignore writes.
- R10: rdata_o holds its value across every cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| side_i | input | 1 | Requester: 0 host, 1 coprocessor |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read request |
| host_irq_o | output | 1 | Work waiting for the host |
| cop_irq_o | output | 1 | Work waiting for the coprocessor |
| err_o | output | 14 | Per-channel refused-access flags |

## Verification
The hardest thing to reach from the ports is a refusal that depends on a state deep in the cycle. Examples are a reply written by the wrong side while a channel sits in received, or a legal-looking step aimed at a channel just past a lowered channel count. Purely random writes seldom walk a channel that far. The random stimulus therefore proposes the legal next state most of the time and picks the side at random, so channels keep circling through all four states with refusals mixed in. Now and then it lowers the channel count. Directed sequences first run one channel per region through a full exchange with replies. They then force refused steps, refused slot writes and out-of-range channels.

// File: rtl/msg_mailbox_pkg.sv
package msg_mailbox_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEW  = 2'd1,
    ST_RCVD = 2'd2,
    ST_DONE = 2'd3
  } ch_state_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_COUNT,
    K_STATE,
    K_MISC,
    K_SLOT
  } acc_kind_e;

  localparam logic [7:0] OFS_COUNT = 8'h00;
  localparam logic [7:0] OFS_STATE = 8'h01;
  localparam logic [7:0] OFS_MISC  = 8'h1F;
  localparam logic [7:0] OFS_SLOT  = 8'h20;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import msg_mailbox_pkg::*;
#(
  parameter int          NCH       = 7,
  parameter int          MSG_LEN   = 32,
  parameter logic [15:0] SEND_BASE = 16'h0200,
  parameter logic [15:0] RECV_BASE = 16'h0300,
  localparam int         CH_W      = $clog2(NCH),
  localparam int         BY_W      = $clog2(MSG_LEN)
) (
  input  logic [15:0]     addr_i,
  output acc_kind_e       kind_o,
  output logic            dir_o,
  output logic [CH_W-1:0] ch_o,
  output logic [BY_W-1:0] byte_o
);
  logic [7:0] off;
  logic [7:0] rel;
  logic       hit;

  assign off = addr_i[7:0];
  assign rel = off - OFS_SLOT;

  always_comb begin
    hit    = 1'b1;
    dir_o  = 1'b0;
    if (addr_i[15:8] == SEND_BASE[15:8])      dir_o = 1'b0;
    else if (addr_i[15:8] == RECV_BASE[15:8]) dir_o = 1'b1;
    else                                      hit   = 1'b0;

    kind_o = K_NONE;
    ch_o   = '0;
    byte_o = '0;
    if (hit) begin
      if (off == OFS_COUNT) begin
        kind_o = K_COUNT;
      end else if (off >= OFS_STATE && int'(off) < int'(OFS_STATE) + NCH) begin
        kind_o = K_STATE;
        ch_o   = CH_W'(off - OFS_STATE);
      end else if (off == OFS_MISC) begin
        kind_o = K_MISC;
      end else if (off >= OFS_SLOT && int'(rel >> BY_W) < NCH) begin
        kind_o = K_SLOT;
        ch_o   = CH_W'(rel >> BY_W);
        byte_o = rel[BY_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mbx_chan_fsm.sv
module mbx_chan_fsm
  import msg_mailbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       st_we_i,
  input  logic       slot_we_i,
  input  logic [7:0] wdata_i,
  input  logic       is_snd_i,
  input  logic       en_i,
  output logic [1:0] state_o,
  output logic       slot_ok_o,
  output logic       err_o
);
  ch_state_e st_q;
  ch_state_e st_nxt;
  logic      snd_turn;
  logic      step_ok;

  assign st_nxt    = ch_state_e'(st_q + 2'd1);
  assign snd_turn  = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign step_ok   = en_i && (wdata_i == {6'b0, st_nxt}) && (is_snd_i == snd_turn);
  assign slot_ok_o = en_i && ((is_snd_i && st_q == ST_IDLE) || (!is_snd_i && st_q == ST_RCVD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_o <= 1'b0;
    end else if (st_we_i) begin
      if (step_ok) begin
        st_q  <= st_nxt;
        err_o <= 1'b0;
      end else begin
        err_o <= 1'b1;
      end
    end else if (slot_we_i && !slot_ok_o) begin
      err_o <= 1'b1;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import msg_mailbox_pkg::*;
#(
  parameter int          NCH       = 7,
  parameter int          MSG_LEN   = 32,
  parameter logic [15:0] SEND_BASE = 16'h0200,
  parameter logic [15:0] RECV_BASE = 16'h0300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              side_i,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              host_irq_o,
  output logic              cop_irq_o,
  output logic [2*NCH-1:0]  err_o
);
  localparam int CH_W   = $clog2(NCH);
  localparam int BY_W   = $clog2(MSG_LEN);
  localparam int NSLOT  = 2 * NCH * MSG_LEN;
  localparam int SLOT_W = $clog2(NSLOT);

  acc_kind_e       dec_kind;
  logic            dec_dir;
  logic [CH_W-1:0] dec_ch;
  logic [BY_W-1:0] dec_byte;

  mbx_addr_dec #(
    .NCH(NCH), .MSG_LEN(MSG_LEN), .SEND_BASE(SEND_BASE), .RECV_BASE(RECV_BASE)
  ) u_dec (
    .addr_i(addr_i), .kind_o(dec_kind), .dir_o(dec_dir), .ch_o(dec_ch), .byte_o(dec_byte)
  );

  logic       wr, rd, is_snd, ch_en;
  logic [7:0] count_q [2];
  logic [7:0] misc_q  [2];
  logic [7:0] slot_mem [NSLOT];

  logic [2*NCH-1:0][1:0] st_all;
  logic [2*NCH-1:0]      slot_ok_all;
  int                    sel, mem_idx;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign is_snd = (side_i == dec_dir);
  assign ch_en  = {{(8-CH_W){1'b0}}, dec_ch} < count_q[dec_dir];
  assign sel    = int'(dec_dir) * NCH + int'(dec_ch);
  assign mem_idx = sel * MSG_LEN + int'(dec_byte);

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int I = d * NCH + c;
      logic hit;
      assign hit = (dec_dir == 1'(d)) && (dec_ch == CH_W'(c));
      mbx_chan_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .st_we_i  (wr && dec_kind == K_STATE && hit),
        .slot_we_i(wr && dec_kind == K_SLOT && hit),
        .wdata_i  (wdata_i),
        .is_snd_i (is_snd),
        .en_i     (ch_en),
        .state_o  (st_all[I]),
        .slot_ok_o(slot_ok_all[I]),
        .err_o    (err_o[I])
      );
    end
  end

  // Level interrupts: each side sees pending work addressed to it
  always_comb begin
    host_irq_o = 1'b0;
    cop_irq_o  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      cop_irq_o  |= (st_all[c] == ST_NEW) || (st_all[NCH+c] == ST_DONE);
      host_irq_o |= (st_all[NCH+c] == ST_NEW) || (st_all[c] == ST_DONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < 2; d++) begin
        count_q[d] <= 8'(NCH);
        misc_q[d]  <= '0;
      end
      for (int i = 0; i < NSLOT; i++) slot_mem[i] <= '0;
    end else if (wr) begin
      case (dec_kind)
        K_COUNT: count_q[dec_dir] <= wdata_i;
        K_MISC:  misc_q[dec_dir]  <= wdata_i;
        K_SLOT:  if (slot_ok_all[sel]) slot_mem[mem_idx[SLOT_W-1:0]] <= wdata_i;
        default: ;
      endcase
    end
  end

  logic [7:0] rd_val;
  always_comb begin
    case (dec_kind)
      K_COUNT: rd_val = count_q[dec_dir];
      K_STATE: rd_val = {6'b0, st_all[sel]};
      K_MISC:  rd_val = misc_q[dec_dir];
      K_SLOT:  rd_val = slot_mem[mem_idx[SLOT_W-1:0]];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk #(
  parameter int          NCH       = 7,
  parameter logic [15:0] SEND_BASE = 16'h0200,
  parameter logic [15:0] RECV_BASE = 16'h0300
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [15:0]           addr_i,
  input logic [7:0]            wdata_i,
  input logic [7:0]            rdata_o,
  input logic                  host_irq_o,
  input logic                  cop_irq_o,
  input logic [2*NCH-1:0]      err_o,
  input logic [2*NCH-1:0][1:0] st_all
);
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  a_r8_cop_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cop_irq_o) |-> $past(req_i && we_i));

  a_r8_host_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $past(req_i && we_i));

  for (genvar i = 0; i < 2 * NCH; i++) begin : g_chk
    localparam logic [15:0] BASE = (i < NCH) ? SEND_BASE : RECV_BASE;
    localparam logic [15:0] SADR = BASE + 16'd1 + 16'(i % NCH);

    a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (st_all[i] == $past(st_all[i])) || (st_all[i] == $past(st_all[i]) + 2'd1));

    a_r6_bad_step_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == SADR && wdata_i != {6'b0, 2'(st_all[i] + 2'd1)})
      |=> (err_o[i] && $stable(st_all[i])));
  end
endmodule

bind msg_mailbox msg_mailbox_chk #(
  .NCH(NCH), .SEND_BASE(SEND_BASE), .RECV_BASE(RECV_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .host_irq_o(host_irq_o),
  .cop_irq_o(cop_irq_o), .err_o(err_o), .st_all(st_all)
);

// File: tb/msg_mailbox_tb.sv
`timescale 1ns/1ps
module msg_mailbox_tb;
  localparam int NCH = 7;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, side = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        host_irq, cop_irq;
  logic [2*NCH-1:0] err;

  always #2 clk = ~clk;

  msg_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .side_i(side),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .host_irq_o(host_irq), .cop_irq_o(cop_irq), .err_o(err)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  int m_st   [2][NCH];
  int m_err  [2][NCH];
  int m_slot [2][NCH][32];
  int m_cnt  [2];
  int m_misc [2];
  int rd_last;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (addr %h)", tag, act, exp, addr);
    end
  endtask

  function automatic int region(int a);
    if (a[15:8] == 8'h02) return 0;
    if (a[15:8] == 8'h03) return 1;
    return -1;
  endfunction

  function automatic int model_read(int a);
    int d = region(a);
    int o = a & 255;
    if (d < 0) return 0;
    if (o == 0) return m_cnt[d];
    if (o >= 1 && o <= NCH) return m_st[d][o-1];
    if (o == 31) return m_misc[d];
    if (o >= 32) return m_slot[d][(o-32)/32][o%32];
    return 0;
  endfunction

  // R3 roles, R4 steps, R5 slot rules, R7 count limit, R9 misc bytes
  function automatic void model_write(int s, int a, int v);
    int d = region(a);
    int o = a & 255;
    int c, st;
    bit snd;
    if (d < 0) return;
    snd = (s == d);
    if (o == 0) m_cnt[d] = v;
    else if (o == 31) m_misc[d] = v;
    else if (o >= 1 && o <= NCH) begin
      c = o - 1; st = m_st[d][c];
      if (c < m_cnt[d] && v == ((st + 1) & 3) && snd == (st == 0 || st == 3)) begin
        m_st[d][c] = v; m_err[d][c] = 0;
      end else m_err[d][c] = 1;
    end else if (o >= 32) begin
      c = (o - 32) / 32; st = m_st[d][c];
      if (c < m_cnt[d] && ((snd && st == 0) || (!snd && st == 2))) m_slot[d][c][o%32] = v;
      else m_err[d][c] = 1;
    end
  endfunction

  task automatic check_outs();
    int ch = 0, hh = 0, e = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m_st[0][c] == 1 || m_st[1][c] == 3) ch = 1;
      if (m_st[1][c] == 1 || m_st[0][c] == 3) hh = 1;
      e |= m_err[0][c] << c;
      e |= m_err[1][c] << (NCH + c);
    end
    chk("R8 cop_irq", int'(cop_irq), ch);
    chk("R8 host_irq", int'(host_irq), hh);
    chk("R6 err", int'(err), e);
    chk("R2/R10 rdata", int'(rdata), rd_last);
  endtask

  task automatic op(bit w, bit s, int a, int v);
    @(negedge clk);
    req = 1'b1; we = w; side = s; addr = 16'(a); wdata = 8'(v);
    if (w) model_write(s, a, v);
    else   rd_last = model_read(a);
    @(negedge clk);
    req = 1'b0;
    check_outs();
  endtask

  task automatic rd(int a); op(1'b0, 1'b0, a, 0); endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int r;
    for (int d = 0; d < 2; d++) begin
      m_cnt[d] = NCH; m_misc[d] = 0;
      for (int c = 0; c < NCH; c++) begin
        m_st[d][c] = 0; m_err[d][c] = 0;
        for (int k = 0; k < 32; k++) m_slot[d][c][k] = 0;
      end
    end
    rd_last = 0;
    r = int'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check_outs();
    rd('h0200); rd('h0300); rd('h0201); rd('h0307); rd('h0220); rd('h03FF);

    // R3/R4/R5 full exchange on outbound channel 6, host sends
    op(1, 0, 'h02E0, 'hA5);
    op(1, 0, 'h0207, 1);
    rd('h02E0);
    op(1, 1, 'h0207, 2);
    op(1, 1, 'h02E1, 'h3C);     // reply while received
    op(1, 1, 'h0207, 3);
    op(1, 0, 'h0207, 0);
    rd('h02E1);
    // R3 inbound channel 0, coprocessor sends
    op(1, 1, 'h0320, 'h77);
    op(1, 1, 'h0301, 1);
    op(1, 0, 'h0301, 2);
    op(1, 0, 'h0301, 3);
    rd('h0301);
    // R4 refused steps
    op(1, 0, 'h0202, 2);        // skip from idle
    op(1, 1, 'h0202, 1);        // receiver posting
    op(1, 0, 'h0202, 'h41);     // upper bits set
    op(1, 0, 'h0202, 1);        // legal, clears flag (R6)
    // R5 refused slot writes
    op(1, 0, 'h0240, 'h11);     // sender while new
    op(1, 1, 'h0240, 'h22);     // receiver while new
    rd('h0240);
    // R7 channel count limit
    op(1, 0, 'h0300, 3);
    rd('h0300);
    op(1, 1, 'h0304, 1);        // channel 3 out of range
    op(1, 1, 'h03A0, 9);
    rd('h03A0);
    op(1, 1, 'h0300, 7);
    // R9 misc bytes and unused offsets
    op(1, 0, 'h021F, 'h5A);
    op(1, 1, 'h031F, 'hC3);
    rd('h021F); rd('h031F);
    op(1, 0, 'h0210, 'hFF);
    rd('h0210);
    op(1, 0, 'h0500, 1);        // R2 outside both regions
    rd('h0500);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int d = $urandom_range(1);
      int c = $urandom_range(NCH - 1);
      int base = d ? 'h0300 : 'h0200;
      int sel = $urandom_range(99);
      bit s = 1'($urandom_range(1));
      if (sel < 45) begin
        int v = ($urandom_range(9) < 8) ? ((m_st[d][c] + 1) & 3) : $urandom_range(3);
        op(1, s, base + 1 + c, v);
      end else if (sel < 70) begin
        op(1, s, base + 32 + 32 * c + $urandom_range(31), $urandom_range(255));
      end else if (sel < 72) begin
        op(1, s, base, $urandom_range(NCH, 3));
      end else if (sel < 74) begin
        op(1, s, base + $urandom_range(8, 31), $urandom_range(255));
      end else begin
        case ($urandom_range(4))
          0: rd(base + 1 + c);
          1: rd(base);
          2: rd(base + $urandom_range(8, 31));
          3: rd('h0400 + $urandom_range(255));
          default: rd(base + 32 + 32 * c + $urandom_range(31));
        endcase
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule